// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that counts a one-cycle tick supplied at instruction rate. A prescaler sits on the tick and passes through one tick in 1, 4 or 16. The counter is compared with a programmable period value on every count step. When the two are equal, the counter goes back to 00h on that step instead of incrementing, and a one-cycle match pulse is issued. The match pulses feed a postscaler that divides them by any ratio from 1 to 16. When the postscaler reaches its terminal count it sets a sticky interrupt flag, which stays set until an explicit clear input clears it.

Software controls the block through three registers: the counter, the period and a control register. It writes them with a strobe, a 2-bit address and a data byte, and reads all three back in parallel. A write to the counter or to the control register restarts both scaler chains. A control write leaves the counter value where it was. Reset is synchronous.

Top module: `period_timer`

## Requirements
- R1: After reset the counter reads 00h, the period reads FFh, the control register reads 00h, and both the match output and the interrupt flag are 0.
- R2: While the enable bit (control bit 2) is 1, the counter advances by one on each count step, beginning from 00h.
- R3: Control bits 1:0 set the prescale ratio: 00 gives one count step per tick, 01 gives one step per 4 ticks, and 10 or 11 give one step per 16 ticks.
- R4: On a count step where the counter equals the period, the counter becomes 00h. The match output is high for exactly the following cycle.
- R5: Control bits 6:3 hold a value N. The interrupt flag sets on every (N+1)-th match.
- R6: A write to the counter (address 0) or to the control register (address 2) clears both the prescaler and the postscaler. No count step happens in that write cycle.
- R7: A control write leaves the counter value unchanged.
- R8: Control bit 7 ignores writes and always reads 0.
- R9: A counter write takes priority over an increment or a match reset in the same cycle.
- R10: The interrupt flag stays set until irq_clr_i is pulsed. If a set and a clear fall in the same cycle, the flag stays set.
- R11: With the enable bit at 0, the counter and both scalers hold their values. Register writes still take effect. The period register is at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle instruction-rate count tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 counter, 1 period, 2 control |
| wr_data_i | input | 8 | Write data |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| count_o | output | 8 | Counter read-back |
| period_o | output | 8 | Period read-back |
| control_o | output | 8 | Control read-back |
| match_o | output | 1 | One-cycle match pulse |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
A prescaler state that should have been cleared shows up as a counter step arriving one to fifteen ticks too early. count_o exposes this on the cycle after the tick that should not have counted. A postscaler error does not appear on the counter. It surfaces only as irq_o setting one or more matches early or late, so the bench counts match pulses against the flag. The bench sweeps every prescale code over several periods and postscale ratios, stopping the tick train one step either side of the interrupt threshold. Any off-by-one in the wrap value, the scaler limits or the terminal compare therefore changes a counter value, a match count or the flag at the final sample.

// File: rtl/period_timer_pkg.sv
package period_timer_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 2;
    localparam int PRE_SEL_W   = 2;
    localparam int POST_SEL_W  = 4;
    localparam int PRE_W       = 4;
    localparam int EN_BIT      = 2;
    localparam int POST_LSB    = 3;
    localparam int POST_MSB    = POST_LSB + POST_SEL_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_COUNT   = 2'd0,
        REG_PERIOD  = 2'd1,
        REG_CONTROL = 2'd2,
        REG_SPARE   = 2'd3
    } reg_sel_e;

    // terminal value of the prescale counter for a select code
    function automatic logic [PRE_W-1:0] pre_limit(input logic [PRE_SEL_W-1:0] sel);
        logic [PRE_W-1:0] lim;
        case (sel)
            2'b00:   lim = PRE_W'(0);
            2'b01:   lim = PRE_W'(3);
            default: lim = PRE_W'(15);
        endcase
        return lim;
    endfunction

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         adv_i,
    input  logic [W-1:0] limit_i,
    output logic         step_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_t;

    pre_t pre_d, pre_q;
    logic at_lim;

    always_comb begin
        pre_d  = pre_q;
        at_lim = (pre_q.cnt == limit_i);
        step_o = adv_i && at_lim;
        if (clr_i) begin
            pre_d.cnt = '0;
        end else if (adv_i) begin
            pre_d.cnt = at_lim ? '0 : pre_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_d;
    end

    // R3: the tick divider never runs past the selected terminal value
    a_r3_pre_in_range: assert property (@(posedge clk) disable iff (rst)
        pre_q.cnt <= limit_i);

    // R6: a clear leaves the divider at zero
    a_r6_pre_cleared: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> pre_q.cnt == '0);

endmodule

// File: rtl/timer_postscaler.sv
module timer_postscaler #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         evt_i,
    input  logic [W-1:0] ratio_i,
    output logic         fire_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } post_t;

    post_t post_d, post_q;
    logic at_term;

    always_comb begin
        post_d  = post_q;
        at_term = (post_q.cnt == ratio_i);
        fire_o  = evt_i && at_term;
        if (clr_i) begin
            post_d.cnt = '0;
        end else if (evt_i) begin
            post_d.cnt = at_term ? '0 : post_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) post_q <= '0;
        else     post_q <= post_d;
    end

    // R5: the match divider stays within the programmed ratio
    a_r5_post_in_range: assert property (@(posedge clk) disable iff (rst)
        post_q.cnt <= ratio_i);

    // R6: a clear leaves the match divider at zero
    a_r6_post_cleared: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> post_q.cnt == '0);

endmodule

// File: rtl/period_timer.sv
module period_timer
    import period_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              irq_clr_i,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] period_o,
    output logic [DATA_W-1:0] control_o,
    output logic              match_o,
    output logic              irq_o
);

    localparam logic [DATA_W-1:0] CTL_MASK = {1'b0, {(DATA_W-1){1'b1}}};

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] per;
        logic [DATA_W-1:0] ctl;
        logic              match;
        logic              irq;
    } core_t;

    core_t core_d, core_q;

    logic wr_cnt, wr_per, wr_ctl, scal_clr, adv, step, hit, evt, fire;

    assign wr_cnt   = wr_en_i && (wr_addr_i == REG_COUNT);
    assign wr_per   = wr_en_i && (wr_addr_i == REG_PERIOD);
    assign wr_ctl   = wr_en_i && (wr_addr_i == REG_CONTROL);
    assign scal_clr = wr_cnt || wr_ctl;
    assign adv      = tick_i && core_q.ctl[EN_BIT] && !scal_clr;
    assign hit      = (core_q.cnt == core_q.per);
    assign evt      = step && hit;

    timer_prescaler #(.W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (scal_clr),
        .adv_i   (adv),
        .limit_i (pre_limit(core_q.ctl[PRE_SEL_W-1:0])),
        .step_o  (step)
    );

    timer_postscaler #(.W(POST_SEL_W)) u_post (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (scal_clr),
        .evt_i   (evt),
        .ratio_i (core_q.ctl[POST_MSB:POST_LSB]),
        .fire_o  (fire)
    );

    always_comb begin
        core_d = core_q;
        if (wr_cnt)      core_d.cnt = wr_data_i;
        else if (evt)    core_d.cnt = '0;
        else if (step)   core_d.cnt = core_q.cnt + DATA_W'(1);
        if (wr_per)      core_d.per = wr_data_i;
        if (wr_ctl)      core_d.ctl = wr_data_i & CTL_MASK;
        core_d.match = evt;
        core_d.irq   = fire || (core_q.irq && !irq_clr_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q.cnt   <= '0;
            core_q.per   <= '1;
            core_q.ctl   <= '0;
            core_q.match <= 1'b0;
            core_q.irq   <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign count_o   = core_q.cnt;
    assign period_o  = core_q.per;
    assign control_o = core_q.ctl;
    assign match_o   = core_q.match;
    assign irq_o     = core_q.irq;

    a_r1_reset_values: assert property (@(posedge clk)
        rst |=> (count_o == '0 && period_o == '1 && control_o == '0 && !match_o && !irq_o));

    a_r4_match_wraps: assert property (@(posedge clk) disable iff (rst)
        match_o |-> count_o == '0);

    a_r7_ctl_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == REG_CONTROL) |=> count_o == $past(count_o));

    a_r9_count_write_wins: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i == REG_COUNT) |=> count_o == $past(wr_data_i));

    a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !irq_clr_i) |=> irq_o);

    a_r11_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!control_o[EN_BIT] && !wr_en_i) |=> $stable(count_o));

endmodule

// File: tb/period_timer_bench.sv
module period_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = 2'd0;
    logic [7:0] wr_data_i = 8'd0;
    logic       irq_clr_i = 1'b0;
    logic [7:0] count_o, period_o, control_o;
    logic       match_o, irq_o;

    int checks = 0;
    int errors = 0;
    int match_seen = 0;

    always #10 clk = ~clk;

    period_timer u_period_timer (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .irq_clr_i (irq_clr_i),
        .count_o   (count_o),
        .period_o  (period_o),
        .control_o (control_o),
        .match_o   (match_o),
        .irq_o     (irq_o)
    );

    always @(negedge clk) if (match_o) match_seen++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        wr_en_i   = 1'b1;
        wr_addr_i = 2'(addr);
        wr_data_i = 8'(data);
        @(negedge clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        int p, n, r, base, c, k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 period", period_o, 255);
        chk("R1 control", control_o, 0);
        chk("R1 match", int'(match_o), 0);
        chk("R1 irq", int'(irq_o), 0);

        // R8 unimplemented control bit
        wr(2, 8'hFF);
        chk("R8 control bit7", control_o, 8'h7F);
        wr(2, 0);

        // R11 disabled: holds, writes still land
        wr(0, 8'h10);
        run_ticks(5);
        @(negedge clk);
        chk("R11 hold when off", count_o, 8'h10);
        wr(0, 8'h33);
        chk("R11 write while off", count_o, 8'h33);
        wr(1, 8'h99);
        chk("R11 period write", period_o, 8'h99);

        // R7 control write leaves counter
        wr(1, 8'hFF);
        wr(0, 8'h20);
        wr(2, 8'h04);
        chk("R7 count after ctl write", count_o, 8'h20);

        // R6 prescaler cleared by control write and by counter write
        wr(2, 8'h05);
        wr(0, 0);
        run_ticks(3);
        chk("R6 partial prescale", count_o, 0);
        wr(2, 8'h05);
        run_ticks(3);
        chk("R6 ctl write clears prescaler", count_o, 0);
        run_ticks(1);
        chk("R3 divide by 4 step", count_o, 1);
        run_ticks(3);
        wr(0, 8'h40);
        run_ticks(3);
        chk("R6 count write clears prescaler", count_o, 8'h40);
        run_ticks(1);
        chk("R2 step after clear", count_o, 8'h41);

        // R4 wrap and match timing
        wr(1, 2);
        wr(2, 8'h04);
        wr(0, 0);
        run_ticks(3);
        chk("R4 count wraps", count_o, 0);
        chk("R4 match pulse", int'(match_o), 1);
        @(negedge clk);
        chk("R4 match one cycle", int'(match_o), 0);

        // R6 postscaler cleared by control write, R5 ratio 1:2
        wr(1, 0);
        wr(2, 8'h0C);
        wr(0, 0);
        clear_irq();
        run_ticks(1);
        @(negedge clk);
        chk("R5 first of two matches", int'(irq_o), 0);
        wr(2, 8'h0C);
        run_ticks(1);
        @(negedge clk);
        chk("R6 ctl write clears postscaler", int'(irq_o), 0);
        run_ticks(1);
        @(negedge clk);
        chk("R5 second match sets irq", int'(irq_o), 1);

        // R10 sticky flag, set beats clear
        repeat (3) @(negedge clk);
        chk("R10 irq sticky", int'(irq_o), 1);
        wr(2, 8'h04);
        tick_i = 1'b1;
        irq_clr_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        irq_clr_i = 1'b0;
        chk("R10 set wins over clear", int'(irq_o), 1);
        clear_irq();
        chk("R10 clear", int'(irq_o), 0);

        // R9 counter write beats increment and match
        wr(1, 8'hFF);
        wr(0, 8'h10);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'h55;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        chk("R9 write beats increment", count_o, 8'h55);
        wr(1, 8'h55);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'h77;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        chk("R9 write beats match", count_o, 8'h77);
        chk("R9 no match pulse", int'(match_o), 0);

        // R2 R3 R4 R5 sweep
        for (int code = 0; code < 4; code++) begin
            for (int pi = 0; pi < 4; pi++) begin
                for (int ni = 0; ni < 2; ni++) begin
                    for (int vi = 0; vi < 2; vi++) begin
                        p = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 3 : 5;
                        n = ni * 2;
                        r = (code == 0) ? 1 : (code == 1) ? 4 : 16;
                        base = (p + 1) * (n + 1);
                        c = (vi == 0) ? base - 1 : base + 1;
                        k = c * r + r - 1;
                        wr(1, p);
                        wr(2, (n << 3) | 4 | code);
                        wr(0, 0);
                        clear_irq();
                        match_seen = 0;
                        run_ticks(k);
                        @(negedge clk);
                        chk("R2 R3 sweep count", count_o, c % (p + 1));
                        chk("R4 sweep matches", match_seen, c / (p + 1));
                        chk("R5 sweep irq", int'(irq_o), int'((c / (p + 1)) >= n + 1));
                    end
                end
            end
        end

        finish_run();
    end

endmodule